// File: doc/BRIEF.md
# Return-Address Shadow Stack Guard

This block sits beside the execute stage of a simple in-order RISC-V core and keeps its own copy of every return address. It looks at each instruction word as it is decoded and sorts it into one of three kinds: a function call, a function return or anything else. For a call it saves the link value, which is the address of the instruction after the call, on an internal stack that software cannot reach. For a return it compares the jump target register with the newest saved entry during the cycle in which the core commits the jump.

When the target agrees with the saved entry, the jump goes ahead and the entry is discarded. When it differs, the guard holds back the program counter update for that jump and then stays locked until reset. While locked it keeps blocking every program counter update, which halts a program whose stack has been overwritten. Linear execution, conditional branches and jumps that are neither calls nor returns pass through untouched. The instruction fetch, the register file and the ALU belong to the core and are not part of this block.

Top module: `ret_guard`

## Requirements
- R1: An instruction decoded with `instr_valid` high counts as a call when it is JAL (opcode 1101111) or JALR (opcode 1100111) and its rd field (bits 11:7) equals 1. Its `link_addr` is saved on the stack at the second rising edge after the decode cycle, and `depth` rises by one at that edge.
- R2: An instruction counts as a return only when it is JALR with rd equal to 0 and rs1 (bits 19:15) equal to 1. The immediate field is not looked at. Branches (opcode 1100011), JAL or JALR to other destinations, and non-jump instructions leave `depth` unchanged and never pull `pc_go` low.
- R3: In the commit cycle of a decoded return (`jump_commit` high), `ret_match` is 1 exactly when `rs1_val` with bit 0 cleared equals the newest stack entry. It is 0 in every other cycle.
- R4: A matching return lowers `depth` by one at the rising edge that ends its commit cycle. Nested calls are checked in last-in, first-out order.
- R5: A return whose target differs drives `pc_go` low in its commit cycle and raises `locked` from the next cycle. While locked, `pc_go` stays 0, `depth` and `overflow` hold their values, and decoded calls are ignored. Only `rst` clears the lock.
- R6: A return committed while `depth` is 0 counts as a mismatch and locks the guard.
- R7: A call whose save falls due while `depth` equals DEPTH (256) raises `overflow` and `locked` at that edge. Nothing is written and `depth` stays at DEPTH.
- R8: The return check is armed by the decode and disarmed at the edge that ends the commit cycle. A `jump_commit` that has no decoded return pending is never gated, gives `ret_match` = 0 and leaves `depth` unchanged.
- R9: With `rst` high at a rising edge (synchronous, active high), the next cycle shows `depth` 0, `locked` 0, `overflow` 0, `pc_go` 1 and `ret_match` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | `instr` is being decoded this cycle |
| instr | input | 32 | Instruction word being decoded |
| link_addr | input | 32 | Address of the instruction after `instr` |
| rs1_val | input | 32 | Value of the jump target register |
| jump_commit | input | 1 | Cycle in which the core writes a jump target into the PC |
| ret_match | output | 1 | Return target equals the newest saved entry |
| pc_go | output | 1 | PC update may proceed this cycle |
| locked | output | 1 | Sticky lockup after a return mismatch or an overflow |
| overflow | output | 1 | A call found the stack full |
| depth | output | 9 | Number of saved return addresses |

## Verification
Calls are decoded in three encodings: JAL to ra, JALR to ra through another register, and JALR to ra through ra itself. The returns then unwind all three, and one of them carries a target with bit 0 set, which shows whether the stack is really last-in, first-out and whether the low bit is cleared before the compare. Lookalike encodings are also committed with garbage targets and must be neither saved nor gated: an ALU write to x1, a jump to x0, an indirect jump through x5 and a branch. A bare commit with no return decoded is included too. Each lockup cause is driven once, separated by resets: a wrong target, a return on an empty stack, and a 257th nested call. In every locked period, calls and commits follow, so that a lock which leaks shows up at the ports.

// File: rtl/ret_guard_pkg.sv
package ret_guard_pkg;

    localparam int XLEN = 32;

    localparam logic [1:0] OPC_LOW_OK  = 2'b11;
    localparam logic [2:0] OPC_CTRL_HI = 3'b110;
    localparam logic [4:0] REG_ZERO    = 5'd0;
    localparam logic [4:0] REG_LINK    = 5'd1;

    typedef enum logic [1:0] {
        IC_OTHER  = 2'd0,
        IC_CALL   = 2'd1,
        IC_RETURN = 2'd2
    } instr_class_e;

    typedef enum logic {
        GS_RUN  = 1'b0,
        GS_LOCK = 1'b1
    } guard_state_e;

    typedef struct packed {
        logic [6:0] opcode;
        logic [4:0] rd;
        logic [4:0] rs1;
    } ctrl_fields_t;

    typedef struct packed {
        logic            push;
        logic            pop;
        logic [XLEN-1:0] wdata;
    } stack_req_t;

    function automatic ctrl_fields_t split_fields(input logic [XLEN-1:0] w);
        ctrl_fields_t f;
        f.opcode = w[6:0];
        f.rd     = w[11:7];
        f.rs1    = w[19:15];
        return f;
    endfunction

    function automatic instr_class_e classify(input logic [XLEN-1:0] w);
        ctrl_fields_t f;
        logic         ctrl_grp;
        logic         is_jump;
        logic         is_jalr;
        f        = split_fields(w);
        ctrl_grp = (f.opcode[6:4] == OPC_CTRL_HI) && (f.opcode[1:0] == OPC_LOW_OK);
        is_jump  = ctrl_grp && f.opcode[2];
        is_jalr  = is_jump && !f.opcode[3];
        if (is_jump && f.rd == REG_LINK)
            return IC_CALL;
        if (is_jalr && f.rd == REG_ZERO && f.rs1 == REG_LINK)
            return IC_RETURN;
        return IC_OTHER;
    endfunction

    function automatic logic [XLEN-1:0] pc_align(input logic [XLEN-1:0] a);
        return {a[XLEN-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/ret_classifier.sv
module ret_classifier
    import ret_guard_pkg::*;
(
    input  logic            valid,
    input  logic [XLEN-1:0] instr,
    output instr_class_e    cls
);
    always_comb begin
        cls = IC_OTHER;
        if (valid)
            cls = classify(instr);
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import ret_guard_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  stack_req_t      req,
    output logic [XLEN-1:0] top,
    output logic [DW-1:0]   depth,
    output logic            empty,
    output logic            full
);
    localparam logic [DW-1:0] FULL_COUNT = DW'(DEPTH);

    logic [XLEN-1:0] mem [DEPTH];
    logic [DW-1:0]   cnt;
    logic [DW-1:0]   top_idx;

    assign top_idx = cnt - 1'b1;
    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_COUNT);
    assign depth   = cnt;
    assign top     = empty ? '0 : mem[top_idx[AW-1:0]];

    always_ff @(posedge clk) begin
        if (req.push && !full)
            mem[cnt[AW-1:0]] <= req.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (req.push && !full && !(req.pop && !empty))
            cnt <= cnt + 1'b1;
        else if (req.pop && !empty && !req.push)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/ret_guard_ctrl.sv
module ret_guard_ctrl
    import ret_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  instr_class_e    cls,
    input  logic [XLEN-1:0] link_addr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic            jump_commit,
    input  logic [XLEN-1:0] top,
    input  logic            empty,
    input  logic            full,
    output stack_req_t      req,
    output logic            ret_match,
    output logic            pc_go,
    output logic            locked,
    output logic            overflow
);
    guard_state_e    state;
    logic            call_pend;
    logic [XLEN-1:0] pend_link;
    logic            chk_armed;
    logic            ovf_q;
    logic            check_en;
    logic            same;

    assign locked   = (state == GS_LOCK);
    assign overflow = ovf_q;
    assign check_en = chk_armed && jump_commit && !locked;
    assign same     = !empty && (pc_align(rs1_val) == top);

    assign ret_match = check_en && same;
    assign pc_go     = !locked && (!check_en || same);

    always_comb begin
        req.push  = call_pend && !full && !locked;
        req.pop   = ret_match;
        req.wdata = pend_link;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= GS_RUN;
            call_pend <= 1'b0;
            pend_link <= '0;
            chk_armed <= 1'b0;
            ovf_q     <= 1'b0;
        end else if (!locked) begin
            call_pend <= (cls == IC_CALL);
            pend_link <= link_addr;
            if (cls == IC_RETURN)
                chk_armed <= 1'b1;
            else if (check_en)
                chk_armed <= 1'b0;
            if (call_pend && full) begin
                ovf_q <= 1'b1;
                state <= GS_LOCK;
            end
            if (check_en && !same)
                state <= GS_LOCK;
        end
    end
endmodule

// File: rtl/ret_guard.sv
module ret_guard
    import ret_guard_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] link_addr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic            jump_commit,
    output logic            ret_match,
    output logic            pc_go,
    output logic            locked,
    output logic            overflow,
    output logic [DW-1:0]   depth
);
    instr_class_e    cls;
    stack_req_t      req;
    logic [XLEN-1:0] top;
    logic            empty;
    logic            full;

    ret_classifier u_cls (
        .valid (instr_valid),
        .instr (instr),
        .cls   (cls)
    );

    ret_stack #(.DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .top   (top),
        .depth (depth),
        .empty (empty),
        .full  (full)
    );

    ret_guard_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cls         (cls),
        .link_addr   (link_addr),
        .rs1_val     (rs1_val),
        .jump_commit (jump_commit),
        .top         (top),
        .empty       (empty),
        .full        (full),
        .req         (req),
        .ret_match   (ret_match),
        .pc_go       (pc_go),
        .locked      (locked),
        .overflow    (overflow)
    );
endmodule

// File: rtl/ret_guard_checker.sv
module ret_guard_checker #(
    parameter int DEPTH = 256,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          jump_commit,
    input logic          ret_match,
    input logic          pc_go,
    input logic          locked,
    input logic          overflow,
    input logic [DW-1:0] depth
);
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    a_r5_lock_blocks_pc: assert property (@(posedge clk) disable iff (rst)
        locked |-> !pc_go);

    a_r5_depth_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(depth));

    a_r5_block_then_lock: assert property (@(posedge clk) disable iff (rst)
        (!locked && !pc_go) |=> locked);

    a_r3_match_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        ret_match |-> (jump_commit && pc_go));

    a_r4_pop_on_match: assert property (@(posedge clk) disable iff (rst)
        ret_match |=> (depth == $past(depth) - 1'b1));

    a_r2_no_gate_without_commit: assert property (@(posedge clk) disable iff (rst)
        (!jump_commit && !locked) |-> pc_go);

    a_r7_overflow_locks: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (locked && depth == DW'(DEPTH)));
endmodule

bind ret_guard ret_guard_checker #(.DEPTH(DEPTH)) u_ret_guard_checker (
    .clk         (clk),
    .rst         (rst),
    .jump_commit (jump_commit),
    .ret_match   (ret_match),
    .pc_go       (pc_go),
    .locked      (locked),
    .overflow    (overflow),
    .depth       (depth)
);

// File: tb/ret_guard_bench.sv
module ret_guard_bench;
    localparam int DEPTH = 256;
    localparam int DW    = 9;

    localparam logic [31:0] I_JAL_RA   = 32'h0000_00EF;
    localparam logic [31:0] I_JALR_RA5 = 32'h0002_80E7;
    localparam logic [31:0] I_JALR_RA1 = 32'h0000_80E7;
    localparam logic [31:0] I_RET      = 32'h0000_8067;
    localparam logic [31:0] I_RET_IMM  = 32'h0040_8067;
    localparam logic [31:0] I_JAL_X0   = 32'h0000_006F;
    localparam logic [31:0] I_JR_X5    = 32'h0002_8067;
    localparam logic [31:0] I_BEQ      = 32'h0000_0063;
    localparam logic [31:0] I_ADDI_X1  = 32'h0010_0093;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [31:0]   link_addr = '0;
    logic [31:0]   rs1_val = '0;
    logic          jump_commit = 1'b0;
    logic          ret_match;
    logic          pc_go;
    logic          locked;
    logic          overflow;
    logic [DW-1:0] depth;

    always #10 clk = ~clk;

    ret_guard u_ret_guard (
        .clk (clk), .rst (rst), .instr_valid (instr_valid), .instr (instr),
        .link_addr (link_addr), .rs1_val (rs1_val), .jump_commit (jump_commit),
        .ret_match (ret_match), .pc_go (pc_go), .locked (locked),
        .overflow (overflow), .depth (depth)
    );

    typedef struct {
        logic          go;
        logic          mt;
        logic          lk;
        logic          ov;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // reference model state, built from the requirements
    logic [31:0] m_stack [DEPTH+1];
    int          m_depth = 0;
    bit          m_pend = 0;
    logic [31:0] m_plink = '0;
    bit          m_armed = 0;
    bit          m_lock = 0;
    bit          m_ovf = 0;

    function automatic int kind(input logic v, input logic [31:0] w);
        bit jal  = (w[6:0] == 7'b1101111);
        bit jalr = (w[6:0] == 7'b1100111);
        if (!v) return 0;
        if ((jal || jalr) && w[11:7] == 5'd1) return 1;
        if (jalr && w[11:7] == 5'd0 && w[19:15] == 5'd1) return 2;
        return 0;
    endfunction

    task automatic step(input logic r, input logic v, input logic [31:0] ins,
                        input logic [31:0] lnk, input logic [31:0] rs,
                        input logic c, input string tag);
        exp_t e;
        bit   chk;
        bit   eq;
        int   k;
        @(posedge clk);
        #1;
        rst = r; instr_valid = v; instr = ins; link_addr = lnk;
        rs1_val = rs; jump_commit = c;
        chk = m_armed && c && !m_lock;
        eq  = (m_depth != 0) && ((rs & 32'hFFFF_FFFE) == m_stack[m_depth-1]);
        e.go = !m_lock && (!chk || eq);
        e.mt = chk && eq;
        e.lk = m_lock;
        e.ov = m_ovf;
        e.d  = DW'(m_depth);
        e.tag = tag;
        q.push_back(e);
        k = kind(v, ins);
        if (r) begin
            m_depth = 0; m_pend = 0; m_armed = 0; m_lock = 0; m_ovf = 0;
        end else if (!m_lock) begin
            if (m_pend) begin
                if (m_depth == DEPTH) begin
                    m_ovf = 1; m_lock = 1;
                end else begin
                    m_stack[m_depth] = m_plink;
                    m_depth++;
                end
            end
            if (chk && eq) m_depth--;
            if (chk && !eq) m_lock = 1;
            m_pend  = (k == 1);
            m_plink = lnk;
            if (k == 2) m_armed = 1;
            else if (chk) m_armed = 0;
        end
    endtask

    task automatic idle(input string tag);
        step(0, 0, 32'h0, 32'h0, 32'h0, 0, tag);
    endtask

    task automatic call_seq(input logic [31:0] ins, input logic [31:0] lnk, input string tag);
        step(0, 1, ins, lnk, 32'h0, 0, tag);
        idle(tag);
        idle(tag);
    endtask

    task automatic ret_seq(input logic [31:0] ins, input logic [31:0] rs, input string tag);
        step(0, 1, ins, 32'h0, 32'h0, 0, tag);
        step(0, 0, 32'h0, 32'h0, rs, 1, tag);
        idle(tag);
    endtask

    // monitor: compares each expected item in its own cycle, away from the edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (pc_go !== e.go || ret_match !== e.mt || locked !== e.lk ||
                    overflow !== e.ov || depth !== e.d) begin
                    n_fail++;
                    $display("FAIL %s: got go=%0b match=%0b lock=%0b ovf=%0b depth=%0d, expected go=%0b match=%0b lock=%0b ovf=%0b depth=%0d",
                             e.tag, pc_go, ret_match, locked, overflow, depth,
                             e.go, e.mt, e.lk, e.ov, e.d);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R9 reset state
        step(1, 0, 32'h0, 32'h0, 32'h0, 0, "R9 reset");
        step(1, 0, 32'h0, 32'h0, 32'h0, 0, "R9 reset");
        idle("R9 after reset");

        // R1 three call encodings
        call_seq(I_JAL_RA,   32'h0000_0100, "R1 jal ra");
        call_seq(I_JALR_RA5, 32'h0000_0204, "R1 jalr ra,x5");
        call_seq(I_JALR_RA1, 32'h0000_0308, "R1 jalr ra,ra");

        // R2 lookalikes committed with garbage targets
        step(0, 1, I_ADDI_X1, 32'h0000_0500, 32'hDEAD_BEEF, 1, "R2 addi x1");
        idle("R2 addi x1");
        step(0, 1, I_JAL_X0, 32'h0000_0504, 32'h1234_5678, 0, "R2 jal x0");
        step(0, 0, 32'h0, 32'h0, 32'h1234_5678, 1, "R2 jal x0 commit");
        step(0, 1, I_JR_X5, 32'h0000_0508, 32'hCAFE_0000, 0, "R2 jr x5");
        step(0, 0, 32'h0, 32'h0, 32'hCAFE_0000, 1, "R2 jr x5 commit");
        step(0, 1, I_BEQ, 32'h0000_050C, 32'h0BAD_0000, 1, "R2 beq");
        idle("R2 beq");

        // R3 R4 unwinding in LIFO order, bit 0 cleared before compare
        ret_seq(I_RET,     32'h0000_0309, "R3 R4 ret to 0x308 with bit0 set");
        ret_seq(I_RET_IMM, 32'h0000_0204, "R3 R4 ret to 0x204 imm ignored");
        ret_seq(I_RET,     32'h0000_0100, "R4 ret to 0x100");

        // R8 bare commit is not gated
        step(0, 0, 32'h0, 32'h0, 32'h0000_0100, 1, "R8 bare commit");
        idle("R8 bare commit");

        // R6 return on empty stack
        ret_seq(I_RET, 32'h0000_0000, "R6 empty return");
        call_seq(I_JAL_RA, 32'h0000_0700, "R5 call while locked");
        step(0, 0, 32'h0, 32'h0, 32'h0, 1, "R5 commit while locked");
        step(1, 0, 32'h0, 32'h0, 32'h0, 0, "R9 reset out of lock");
        idle("R9 after lock reset");

        // R5 wrong target
        call_seq(I_JAL_RA, 32'h0000_0400, "R5 setup call");
        ret_seq(I_RET, 32'h0000_0404, "R5 mismatch");
        call_seq(I_JALR_RA5, 32'h0000_0800, "R5 call while locked");
        ret_seq(I_RET, 32'h0000_0400, "R5 right target while locked");
        step(1, 0, 32'h0, 32'h0, 32'h0, 0, "R9 reset");
        idle("R9 after reset");

        // R7 overflow
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 1, I_JAL_RA, 32'h0001_0000 + 32'(i * 4), 32'h0, 0, "R7 fill");
            idle("R7 fill");
        end
        call_seq(I_JAL_RA, 32'h0002_0000, "R7 overflow call");
        ret_seq(I_RET, 32'h0001_03FC, "R7 return after overflow");

        step(1, 0, 32'h0, 32'h0, 32'h0, 0, "R9 final reset");
        idle("R9 final");
        wait (q.size() == 0);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule